// File: doc/BRIEF.md
# Double-Buffered Operand Stream Buffer

This block sits between a memory port and an arithmetic pipeline. It keeps the pipeline supplied with a steady stream of operand pairs, and it carries the pipeline's results back to memory. It holds three double buffers. Two of them, X and Y, hold input operands. The third, Z, collects results. Each half of a double buffer stores one octet of eight words. While one half is being filled from memory (or drained to memory, for Z), the other half serves the pipeline. This hides memory latency behind the pipeline's own consumption.

When the pipeline needs a result it has just produced as an operand, a forward request copies a complete Z octet straight into the filling half of X or Y. The result then skips the trip out to memory and back. The copied octet is still written back to memory as usual.

Memory words arrive on a valid/ready stream tagged with their destination buffer. Results leave on a second valid/ready stream. Operand pairs and results use valid/ready handshakes toward the pipeline.

Top module: `operand_buffer_unit`

## Requirements
- R1: During and just after reset, both X and Y and the whole Z buffer are empty. So opValid=0, memWrValid=0, resReady=1, memRdReady=1 and fwdReady=0.
- R2: A memory word is accepted when memRdValid and memRdReady are both high. It is stored in the filling half of the buffer chosen by memRdSel, at the next free position in arrival order. memRdReady is low while that filling half already holds 8 words.
- R3: A double buffer hands its filling half over to serving when two conditions hold together: the filling half is full, and the serving half is empty or is giving up its last word in that same cycle. There is no bubble between two back-to-back octets.
- R4: opValid is high only when both the X and Y serving halves hold a word. The k-th pair issued carries the k-th word of the served X octet on opA and of the served Y octet on opB. While opReady is low, the pair is held unchanged.
- R5: A result is accepted when resValid and resReady are both high. It is appended to the Z filling half. resReady is low while that half holds 8 words.
- R6: A full Z octet is written to memory in the order it was collected, one word per memWrValid/memWrReady handshake. While memWrReady is low, the word is held unchanged.
- R7: fwdReady is high only when the Z filling half holds a complete octet and the destination filling half is empty. While Z is still collecting, a forward request waits. An accepted forward copies all 8 Z words in one cycle, and the destination half is full on the next cycle.
- R8: When a forward is accepted into the same buffer that memRdSel selects, the forward wins. memRdReady is low in that cycle and the memory word is not taken.
- R9: A Z octet that has been forwarded is not consumed by the forward. It is still handed over for draining and written back to memory in full.
- R10: The codes are as follows. memRdSel and fwdDest both use 0 for X and 1 for Y. opA comes from X and opB comes from Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memRdValid | input | 1 | Memory word available |
| memRdSel | input | 1 | Destination of memory word: 0 = X, 1 = Y |
| memRdData | input | DATA_W | Memory word |
| memRdReady | output | 1 | Memory word will be taken |
| memWrValid | output | 1 | Result word available for memory |
| memWrData | output | DATA_W | Result word to memory |
| memWrReady | input | 1 | Memory takes the result word |
| opValid | output | 1 | Operand pair available |
| opReady | input | 1 | Pipeline takes the pair |
| opA | output | DATA_W | Operand from X |
| opB | output | DATA_W | Operand from Y |
| resValid | input | 1 | Result from pipeline available |
| resData | input | DATA_W | Result word |
| resReady | output | 1 | Result will be taken |
| fwdValid | input | 1 | Request to copy the Z octet |
| fwdDest | input | 1 | Copy destination: 0 = X, 1 = Y |
| fwdReady | output | 1 | Forward copy happens this cycle |

## Verification
The sharpest collision is between a forward copy and a memory load aimed at the same filling half in the same cycle. Both want to write that half, and only the forward may win. The bench provokes this collision by running long phases with forward requests and memory loads both frequent and the destination chosen at random. It counts how often the collision actually occurs and requires a non-zero count. A reference model built from queues judges each such cycle: memRdReady must drop, and the octet later served to the pipeline must be the copied Z words with no stray memory word among them.

// File: rtl/obuf_pkg.sv
package obuf_pkg;

  localparam int OCT_DEPTH = 8;
  localparam int NUM_IN    = 2;
  localparam int IDX_W     = $clog2(OCT_DEPTH);
  localparam int CNT_W     = $clog2(OCT_DEPTH + 1);
  localparam int SEL_W     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  // Strobes from control to datapath. Index NUM_IN is the result buffer.
  typedef struct packed {
    logic [NUM_IN-1:0]             loadWr;
    logic [NUM_IN-1:0]             fwdCopy;
    logic                          resWr;
    logic [NUM_IN:0]               fillHalf;
    logic [NUM_IN:0][IDX_W-1:0]    fillIdx;
    logic [NUM_IN:0][IDX_W-1:0]    readIdx;
  } obufStrobe_t;

endpackage

// File: rtl/obuf_ctrl.sv
module obuf_ctrl
  import obuf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             memRdValid,
  input  logic [SEL_W-1:0] memRdSel,
  input  logic             memWrReady,
  input  logic             opReady,
  input  logic             resValid,
  input  logic             fwdValid,
  input  logic [SEL_W-1:0] fwdDest,
  output logic             memRdReady,
  output logic             memWrValid,
  output logic             opValid,
  output logic             resReady,
  output logic             fwdReady,
  output obufStrobe_t      strobe
);

  localparam int ZB = NUM_IN;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(OCT_DEPTH);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(OCT_DEPTH - 1);

  logic [CNT_W-1:0] fillCnt   [NUM_IN+1];
  logic             fillHalf  [NUM_IN+1];
  logic             servValid [NUM_IN+1];
  logic [IDX_W-1:0] readIdx   [NUM_IN+1];
  logic             fillAcc   [NUM_IN+1];
  logic             fillSet   [NUM_IN+1];
  logic             advance   [NUM_IN+1];
  logic             loadOk    [NUM_IN];
  logic             fwdHit    [NUM_IN];
  logic             zFull;
  logic             opFire;

  assign zFull    = (fillCnt[ZB] == FULL);
  assign fwdReady = zFull && (fillCnt[fwdDest] == '0);
  assign resReady = !zFull;
  assign memWrValid = servValid[ZB];

  always_comb begin
    opValid = 1'b1;
    for (int i = 0; i < NUM_IN; i++) opValid = opValid && servValid[i];
  end
  assign opFire = opValid && opReady;

  assign memRdReady = loadOk[memRdSel];

  // Per input buffer: forward beats memory load into the same half.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    assign fwdHit[i]  = fwdValid && fwdReady && (fwdDest == SEL_W'(i));
    assign loadOk[i]  = (fillCnt[i] != FULL) && !fwdHit[i];
    assign fillAcc[i] = memRdValid && (memRdSel == SEL_W'(i)) && loadOk[i];
    assign fillSet[i] = fwdHit[i];
    assign advance[i] = opFire;
  end

  assign fillAcc[ZB] = resValid && resReady;
  assign fillSet[ZB] = 1'b0;
  assign advance[ZB] = servValid[ZB] && memWrReady;

  // One ping-pong controller per double buffer.
  for (genvar b = 0; b <= NUM_IN; b++) begin : g_buf
    logic [CNT_W-1:0] cntQ;
    logic             halfQ;
    logic             liveQ;
    logic [IDX_W-1:0] idxQ;
    logic             lastOut;
    logic             swap;

    assign lastOut = advance[b] && (idxQ == LAST);
    assign swap    = (cntQ == FULL) && (!liveQ || lastOut);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ  <= '0;
        halfQ <= 1'b0;
        liveQ <= 1'b0;
        idxQ  <= '0;
      end else if (swap) begin
        cntQ  <= '0;
        halfQ <= !halfQ;
        liveQ <= 1'b1;
        idxQ  <= '0;
      end else begin
        if (fillSet[b])      cntQ <= FULL;
        else if (fillAcc[b]) cntQ <= cntQ + 1'b1;
        if (advance[b]) begin
          if (lastOut) begin
            liveQ <= 1'b0;
            idxQ  <= '0;
          end else begin
            idxQ  <= idxQ + 1'b1;
          end
        end
      end
    end

    assign fillCnt[b]   = cntQ;
    assign fillHalf[b]  = halfQ;
    assign servValid[b] = liveQ;
    assign readIdx[b]   = idxQ;

    // A forward copy leaves the destination half full (R7).
    assert_fwd_fills_R7: assert property (@(posedge clk) disable iff (!rstN)
      fillSet[b] |=> (cntQ == FULL))
      else $error("forward did not fill destination half");
  end

  always_comb begin
    strobe = '0;
    for (int b = 0; b <= NUM_IN; b++) begin
      strobe.fillHalf[b] = fillHalf[b];
      strobe.fillIdx[b]  = fillCnt[b][IDX_W-1:0];
      strobe.readIdx[b]  = readIdx[b];
    end
    for (int i = 0; i < NUM_IN; i++) begin
      strobe.loadWr[i]  = fillAcc[i];
      strobe.fwdCopy[i] = fwdHit[i];
    end
    strobe.resWr = fillAcc[ZB];
  end

  // Result acceptance stops only after a result was taken (R5).
  assert_res_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resReady) |-> $past(resValid))
    else $error("resReady fell without a result");

endmodule

// File: rtl/obuf_datapath.sv
module obuf_datapath
  import obuf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  obufStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] resData,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] memWrData
);

  localparam int ZB = NUM_IN;

  logic [DATA_W-1:0] zMem   [2][OCT_DEPTH];
  logic [DATA_W-1:0] zOct   [OCT_DEPTH];
  logic [DATA_W-1:0] rdWord [NUM_IN];

  always_ff @(posedge clk) begin
    if (strobe.resWr) zMem[strobe.fillHalf[ZB]][strobe.fillIdx[ZB]] <= resData;
  end

  always_comb begin
    for (int k = 0; k < OCT_DEPTH; k++) zOct[k] = zMem[strobe.fillHalf[ZB]][k];
  end

  assign memWrData = zMem[!strobe.fillHalf[ZB]][strobe.readIdx[ZB]];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic [DATA_W-1:0] mem [2][OCT_DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.fwdCopy[i]) begin
        for (int k = 0; k < OCT_DEPTH; k++) mem[strobe.fillHalf[i]][k] <= zOct[k];
      end else if (strobe.loadWr[i]) begin
        mem[strobe.fillHalf[i]][strobe.fillIdx[i]] <= memRdData;
      end
    end

    assign rdWord[i] = mem[!strobe.fillHalf[i]][strobe.readIdx[i]];
  end

  assign opA = rdWord[0];
  assign opB = rdWord[1];

endmodule

// File: rtl/operand_buffer_unit.sv
module operand_buffer_unit
  import obuf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memRdValid,
  input  logic [SEL_W-1:0]  memRdSel,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memRdReady,
  output logic              memWrValid,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrReady,
  output logic              opValid,
  input  logic              opReady,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  input  logic              resValid,
  input  logic [DATA_W-1:0] resData,
  output logic              resReady,
  input  logic              fwdValid,
  input  logic [SEL_W-1:0]  fwdDest,
  output logic              fwdReady
);

  obufStrobe_t strobe;

  obuf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .memRdValid (memRdValid),
    .memRdSel   (memRdSel),
    .memWrReady (memWrReady),
    .opReady    (opReady),
    .resValid   (resValid),
    .fwdValid   (fwdValid),
    .fwdDest    (fwdDest),
    .memRdReady (memRdReady),
    .memWrValid (memWrValid),
    .opValid    (opValid),
    .resReady   (resReady),
    .fwdReady   (fwdReady),
    .strobe     (strobe)
  );

  obuf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .memRdData (memRdData),
    .resData   (resData),
    .opA       (opA),
    .opB       (opB),
    .memWrData (memWrData)
  );

  // A stalled operand pair stays put (R4).
  assert_op_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opReady) |=> (opValid && $stable(opA) && $stable(opB)))
    else $error("operand pair changed while stalled");

  // A stalled write-back word stays put (R6).
  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady) |=> (memWrValid && $stable(memWrData)))
    else $error("write-back word changed while stalled");

  // Forward wins over a memory load into the same buffer (R8).
  assert_fwd_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdReady && memRdValid && (memRdSel == fwdDest)) |-> !memRdReady)
    else $error("memory load accepted alongside forward");

endmodule

// File: tb/operand_buffer_unit_bench.sv
`timescale 1ns/1ps
module operand_buffer_unit_bench;

  typedef logic [31:0] word_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memRdValid = 0, memRdSel = 0, memWrReady = 0, opReady = 0;
  logic        resValid = 0, fwdValid = 0, fwdDest = 0;
  word_t       memRdData = '0, resData = '0;
  logic        memRdReady, memWrValid, opValid, resReady, fwdReady;
  word_t       memWrData, opA, opB;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  int nConflict = 0;
  int nFwd = 0;

  word_t xFill[$], yFill[$], xServ[$], yServ[$], zFill[$], zDrain[$];

  always #10 clk = ~clk;

  operand_buffer_unit #(.DATA_W(32)) u_operand_buffer_unit (
    .clk(clk), .rstN(rstN),
    .memRdValid(memRdValid), .memRdSel(memRdSel), .memRdData(memRdData),
    .memRdReady(memRdReady),
    .memWrValid(memWrValid), .memWrData(memWrData), .memWrReady(memWrReady),
    .opValid(opValid), .opReady(opReady), .opA(opA), .opB(opB),
    .resValid(resValid), .resData(resData), .resReady(resReady),
    .fwdValid(fwdValid), .fwdDest(fwdDest), .fwdReady(fwdReady)
  );

  task automatic chk(input string tag, input word_t got, input word_t exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare all outputs against the queue model, then advance the model.
  task automatic compareAndStep();
    bit expOp, expWr, zFullE, fwdOk, ldX, ldY, pop, wrDone, resAcc;
    bit swX, swY, swZ, rdyE;
    int xF, yF, xS, yS, zF, zD;
    xF = xFill.size(); yF = yFill.size(); xS = xServ.size(); yS = yServ.size();
    zF = zFill.size(); zD = zDrain.size();
    expOp  = (xS > 0) && (yS > 0);
    expWr  = (zD > 0);
    zFullE = (zF == 8);
    fwdOk  = zFullE && (fwdDest ? (yF == 0) : (xF == 0));
    rdyE   = (memRdSel ? (yF < 8) : (xF < 8)) && !(fwdValid && fwdOk && fwdDest == memRdSel);

    chk("R4 opValid (both serving halves)", word_t'(opValid), word_t'(expOp));
    if (expOp && opValid) begin
      chk("R4/R10 opA from X", opA, xServ[0]);
      chk("R4/R10 opB from Y", opB, yServ[0]);
    end
    chk("R2/R8/R10 memRdReady", word_t'(memRdReady), word_t'(rdyE));
    chk("R5 resReady", word_t'(resReady), word_t'(!zFullE));
    chk("R7 fwdReady", word_t'(fwdReady), word_t'(fwdOk));
    chk("R6 memWrValid", word_t'(memWrValid), word_t'(expWr));
    if (expWr && memWrValid) chk("R6/R9 memWrData order", memWrData, zDrain[0]);

    pop    = expOp && opReady;
    wrDone = expWr && memWrReady;
    fwdOk  = fwdOk && fwdValid;
    ldX    = memRdValid && !memRdSel && (xF < 8) && !(fwdOk && !fwdDest);
    ldY    = memRdValid &&  memRdSel && (yF < 8) && !(fwdOk &&  fwdDest);
    resAcc = resValid && !zFullE;
    swX    = (xF == 8) && ((xS == 0) || (pop && xS == 1));
    swY    = (yF == 8) && ((yS == 0) || (pop && yS == 1));
    swZ    = (zF == 8) && ((zD == 0) || (wrDone && zD == 1));

    if (fwdOk && memRdValid && memRdSel == fwdDest) nConflict++;
    if (fwdOk) nFwd++;

    if (pop) begin void'(xServ.pop_front()); void'(yServ.pop_front()); end
    if (wrDone) void'(zDrain.pop_front());
    if (fwdOk) begin
      if (fwdDest) yFill = zFill; else xFill = zFill;
    end
    if (ldX) xFill.push_back(memRdData);
    if (ldY) yFill.push_back(memRdData);
    if (swX) begin xServ = xFill; xFill = {}; end
    if (swY) begin yServ = yFill; yFill = {}; end
    if (resAcc) zFill.push_back(resData);
    if (swZ) begin zDrain = zFill; zFill = {}; end
  endtask

  task automatic runCycles(input int n, input int pLoad, input int pOp, input int pRes,
                           input int pWr, input int pFwd, input bit altSel);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      memRdValid = ($urandom % 100) < pLoad;
      memRdSel   = altSel ? c[0] : $urandom % 2;
      memRdData  = $urandom;
      opReady    = ($urandom % 100) < pOp;
      resValid   = ($urandom % 100) < pRes;
      resData    = $urandom;
      memWrReady = ($urandom % 100) < pWr;
      fwdValid   = ($urandom % 100) < pFwd;
      fwdDest    = $urandom % 2;
      #1;
      compareAndStep();
    end
  endtask

  initial begin
    int run;
    repeat (3) @(negedge clk);
    // R1: reset state with idle inputs.
    chk("R1 opValid in reset", word_t'(opValid), 0);
    chk("R1 memWrValid in reset", word_t'(memWrValid), 0);
    chk("R1 resReady in reset", word_t'(resReady), 1);
    chk("R1 memRdReady in reset", word_t'(memRdReady), 1);
    chk("R1 fwdReady in reset", word_t'(fwdReady), 0);
    rstN = 1'b1;

    // R2/R3: fill two octets in X and Y with the pipeline stalled.
    runCycles(40, 100, 0, 0, 0, 0, 1'b1);
    chk("R2 X fill half full after preload", xFill.size(), 8);
    // Drain with opReady held high: 16 back-to-back pairs expected (R3).
    run = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      memRdValid = 0; opReady = 1; resValid = 0; fwdValid = 0; memWrReady = 0;
      #1;
      if (opValid) run++;
      compareAndStep();
    end
    chk("R3 back-to-back octets without bubble", run, 16);

    // Mixed traffic phases.
    runCycles(1500, 70, 90, 70, 90, 10, 1'b0);
    runCycles(1500, 30, 50, 80, 20, 50, 1'b0);
    runCycles(1500, 90, 30, 60, 60, 60, 1'b0);
    runCycles(1000, 50, 100, 100, 100, 30, 1'b0);

    chk("R7 forwards occurred", word_t'(nFwd > 0), 1);
    chk("R8 forward/load collisions occurred", word_t'(nConflict > 0), 1);
    // R9: drain everything; forwarded octets must still appear on memWr.
    runCycles(100, 0, 100, 0, 100, 0, 1'b0);
    chk("R9 all Z octets written back", zDrain.size() + zFill.size(), zFill.size());

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule